// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control and status logic in front of a multi-channel analog-to-digital converter. Software sees one 8-bit control/status word and one 10-bit result word for each channel. A conversion can run in one of three ways. Single mode converts one chosen channel once. Multi mode converts a group of channels once, in ascending order. Scan mode keeps cycling through the group until software stops it. A conversion starts on a software write of the start bit or on a falling edge of an external trigger pin.

The analog converter itself sits outside. The block drives a one-cycle start pulse together with a channel number, then waits for a done pulse that carries the result. When a pass completes, the block sets an end flag. If the interrupt is enabled, the flag raises the interrupt line. Software clears the flag in two steps: it reads the status while the flag is set, then writes a 0 to the flag bit. A DMA engine clears the flag by reading a result word.

The control/status word has this layout:

| Bit | Meaning |
|-----|---------|
| 7 | end flag |
| 6 | interrupt enable |
| 5 | start/busy |
| 4:3 | mode: 00 single, 01 multi, 10 scan, 11 behaves as multi |
| 2 | reserved, reads 0 |
| 1:0 | highest channel of the group |

In single mode, the channel converted is the one named in bits 1:0.

Bus addresses:

| Address | Register |
|---------|----------|
| 0 | control/status word |
| 4+k | result word of channel k |
| other | reads 0 |

`busRdata` always shows the addressed register. `busRd` marks an actual read access. `busDma` marks that access as coming from the DMA engine.

Top module: `adc_seq`

## Requirements
- R1: After reset, the control/status word reads 0x00, every result word reads 0, `irq` is 0 and `convStart` is 0.
- R2: Bit 2 of the control/status word always reads 0. Writing 1 to bit 7 never sets the flag. The mode and channel fields ignore writes while bit 5 is 1.
- R3: A write of 0 to bit 7 clears the flag only when the previous control/status access was a read made while the flag was 1. Any other write leaves the flag unchanged.
- R4: A read of a result word with `busDma`=1 clears the flag. The same read with `busDma`=0 leaves the flag set.
- R5: `irq` is 1 exactly when both the flag and bit 6 are 1.
- R6: In single mode, a start converts only the channel given in bits 1:0. On the edge that accepts the done pulse, the block stores the result in that channel's result word, sets the flag and clears bit 5. Bit 5 reads 1 from the start until then.
- R7: In multi mode, the block converts channels 0 to bits 1:0 in ascending order and stores each result in its own result word. It sets the flag and clears bit 5 only after the last channel finishes.
- R8: In scan mode, conversion wraps from the last channel back to channel 0 without stopping. The flag sets after each complete pass, and bit 5 stays 1.
- R9: Writing 0 to bit 5 during a multi or scan conversion lets the channel in progress finish and store its result, then stops. No further `convStart` follows. If that channel was not the last one of a pass, the flag stays unchanged.
- R10: `trigN` passes through a two-stage synchronizer, and only its falling edge starts a conversion. A rising edge has no effect. So does a falling edge while a conversion is running, or a write of 1 to bit 5 while one is running.
- R11: `standbyReq`=1 stops a conversion at the next edge. Bit 5 clears, the flag does not set, and a result still in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standbyReq | input | 1 | Standby request, aborts any conversion |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read access strobe |
| busDma | input | 1 | Marks the current read as a DMA access |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 10 | Read data of the addressed register |
| trigN | input | 1 | External trigger, active on falling edge |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convCh | output | 2 | Channel to convert |
| convDone | input | 1 | One-cycle done pulse from the converter |
| convResult | input | 10 | Conversion result, valid with convDone |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The assertions assume the converter behaves as a well-formed handshake partner:
- It returns exactly one one-cycle `convDone` for each `convStart`, and only after that start.
- `busWr` and `busRd` are never high in the same cycle.

The converter model in the bench answers each start pulse after a fixed three-cycle latency, tagging every result with its channel and a running count. All bus traffic is issued one access at a time, outside the clock edge. The standby and stop cases are placed at cycles where a conversion is known to be in flight, so the abort paths are reached without breaking that handshake.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_W    = 8;
  localparam int CH_SEL_W = 2;
  localparam int NUM_CH   = 1 << CH_SEL_W;
  localparam int ADDR_W   = CH_SEL_W + 1;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_RSVD   = 2'b11
  } convMode_e;

  typedef struct packed {
    logic                storeEn;
    logic [CH_SEL_W-1:0] storeCh;
    logic                setFlag;
  } seqStrobe_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigN,
  output logic trigFall
);
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[SYNC_STAGES-1:0], trigN};
  end

  assign trigFall = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                standbyReq,
  input  logic                startSet,
  input  logic                startClr,
  input  logic                trigFall,
  input  convMode_e           cfgMode,
  input  logic [CH_SEL_W-1:0] cfgCh,
  input  logic [CH_SEL_W-1:0] chSelReg,
  input  logic                convDone,
  output seqStrobe_t          stb,
  output logic                startBit,
  output logic                convStart,
  output logic [CH_SEL_W-1:0] convCh
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seqState_e;

  seqState_e           state;
  logic                stopPend;
  logic [CH_SEL_W-1:0] curCh;
  logic [CH_SEL_W-1:0] runCh;
  convMode_e           runMode;

  logic doneNow, lastCh, stopNow, isSingle;

  assign isSingle = (runMode == MODE_SINGLE);
  assign doneNow  = (state == ST_WAIT) && convDone;
  assign lastCh   = isSingle || (curCh == runCh);
  assign stopNow  = stopPend || startClr;

  always_comb begin
    stb.storeEn = doneNow && !standbyReq;
    stb.storeCh = curCh;
    stb.setFlag = doneNow && !standbyReq && lastCh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      startBit <= 1'b0;
      stopPend <= 1'b0;
      curCh    <= '0;
      runCh    <= '0;
      runMode  <= MODE_SINGLE;
    end else if (standbyReq) begin
      state    <= ST_IDLE;
      startBit <= 1'b0;
      stopPend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startSet || trigFall) begin
            startBit <= 1'b1;
            stopPend <= 1'b0;
            runMode  <= cfgMode;
            runCh    <= cfgCh;
            curCh    <= (cfgMode == MODE_SINGLE) ? cfgCh : '0;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          state <= ST_WAIT;
          if (startClr) stopPend <= 1'b1;
        end
        ST_WAIT: begin
          if (doneNow) begin
            if (isSingle) begin
              state    <= ST_IDLE;
              startBit <= 1'b0;
              stopPend <= 1'b0;
            end else if (lastCh) begin
              if (runMode == MODE_SCAN && !stopNow) begin
                curCh <= '0;
                state <= ST_ISSUE;
              end else begin
                state    <= ST_IDLE;
                startBit <= 1'b0;
                stopPend <= 1'b0;
              end
            end else if (stopNow) begin
              state    <= ST_IDLE;
              startBit <= 1'b0;
              stopPend <= 1'b0;
            end else begin
              curCh <= curCh + CH_SEL_W'(1);
              state <= ST_ISSUE;
            end
          end else if (startClr) begin
            stopPend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convStart = (state == ST_ISSUE);
  assign convCh    = curCh;

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_ch_in_group_R7: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (convCh <= chSelReg));

  assert_stop_on_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> $past(convDone || standbyReq));

  assert_standby_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    standbyReq |=> !startBit);
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic                busDma,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CSR_W-1:0]    busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [DATA_W-1:0]   convResult,
  input  seqStrobe_t          stb,
  input  logic                startBit,
  output convMode_e           cfgMode,
  output logic [CH_SEL_W-1:0] cfgCh,
  output logic [CH_SEL_W-1:0] chSelReg,
  output logic                startSet,
  output logic                startClr,
  output logic                flagOut,
  output logic                irq
);
  logic                flag, intEn, armed;
  convMode_e           modeReg;
  logic                isCsr, isData, csrWr, csrRd, dmaClr, cfgWrOk;
  logic [CH_SEL_W-1:0] dataIdx;
  logic [CSR_W-1:0]    csrRead;
  logic [DATA_W-1:0]   chData [NUM_CH];
  logic                unusedBits;

  assign unusedBits = busWdata[2];

  assign isCsr   = (busAddr == '0);
  assign isData  = busAddr[ADDR_W-1];
  assign dataIdx = busAddr[CH_SEL_W-1:0];
  assign csrWr   = busWr && isCsr;
  assign csrRd   = busRd && isCsr;
  assign dmaClr  = busRd && busDma && isData;
  assign cfgWrOk = csrWr && !startBit;

  assign startSet = csrWr && busWdata[5];
  assign startClr = csrWr && !busWdata[5];

  assign cfgMode = cfgWrOk ? convMode_e'(busWdata[4:3]) : modeReg;
  assign cfgCh   = cfgWrOk ? busWdata[1:0] : chSelReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_SINGLE;
      chSelReg <= '0;
      intEn    <= 1'b0;
    end else if (csrWr) begin
      intEn <= busWdata[6];
      if (!startBit) begin
        modeReg  <= convMode_e'(busWdata[4:3]);
        chSelReg <= busWdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                armed <= 1'b0;
    else if (csrWr)           armed <= 1'b0;
    else if (csrRd && flag)   armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       flag <= 1'b0;
    else if (stb.setFlag)                            flag <= 1'b1;
    else if ((csrWr && !busWdata[7] && armed) || dmaClr) flag <= 1'b0;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic [DATA_W-1:0] held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) held <= '0;
      else if (stb.storeEn && stb.storeCh == CH_SEL_W'(k)) held <= convResult;
    end
    assign chData[k] = held;
  end

  assign csrRead = {flag, intEn, startBit, modeReg, 1'b0, chSelReg};

  always_comb begin
    busRdata = '0;
    if (isCsr)       busRdata = DATA_W'(csrRead);
    else if (isData) busRdata = chData[dataIdx];
  end

  assign flagOut = flag;
  assign irq     = flag && intEn;

  assert_flag_clear_by_access_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(busWr || (busRd && busDma)));

  assert_flag_write1_noset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && csrWr && busWdata[7] && !stb.setFlag) |=> !flag);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                standbyReq,
  input  logic                busWr,
  input  logic                busRd,
  input  logic                busDma,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CSR_W-1:0]    busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                trigN,
  output logic                convStart,
  output logic [CH_SEL_W-1:0] convCh,
  input  logic                convDone,
  input  logic [DATA_W-1:0]   convResult,
  output logic                irq
);
  seqStrobe_t          stb;
  logic                startBit, startSet, startClr, trigFall, flagOut;
  convMode_e           cfgMode;
  logic [CH_SEL_W-1:0] cfgCh, chSelReg;

  adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .trigN(trigN), .trigFall(trigFall));

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .standbyReq(standbyReq),
    .startSet(startSet), .startClr(startClr), .trigFall(trigFall),
    .cfgMode(cfgMode), .cfgCh(cfgCh), .chSelReg(chSelReg),
    .convDone(convDone), .stb(stb), .startBit(startBit),
    .convStart(convStart), .convCh(convCh));

  adc_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busDma(busDma),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .convResult(convResult), .stb(stb), .startBit(startBit),
    .cfgMode(cfgMode), .cfgCh(cfgCh), .chSelReg(chSelReg),
    .startSet(startSet), .startClr(startClr), .flagOut(flagOut), .irq(irq));

  assert_flag_set_on_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOut) |-> $past(convDone));
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standbyReq = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0, busDma = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [9:0] busRdata;
  logic       trigN = 1'b1;
  logic       convStart;
  logic [1:0] convCh;
  logic       convDone = 1'b0;
  logic [9:0] convResult = '0;
  logic       irq;

  int total = 0, bad = 0, cycles = 0;
  int chLog [64];
  int logN = 0;
  int lastRes [4];
  int cnt = 0, pendCh = 0, resSeq = 0;

  adc_seq u_dut (
    .clk(clk), .rstN(rstN), .standbyReq(standbyReq), .busWr(busWr),
    .busRd(busRd), .busDma(busDma), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .trigN(trigN), .convStart(convStart), .convCh(convCh),
    .convDone(convDone), .convResult(convResult), .irq(irq));

  always #4 clk = ~clk;

  // converter model: answers each start after three cycles
  always @(negedge clk) begin
    convDone = 1'b0;
    if (!rstN) cnt = 0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        resSeq++;
        convResult = 10'((pendCh << 8) | (resSeq & 8'hff));
        lastRes[pendCh] = int'(convResult);
        convDone = 1'b1;
      end
    end
    if (rstN && convStart) begin
      pendCh = int'(convCh);
      cnt = 3;
      if (logN < 64) chLog[logN] = int'(convCh);
      logN++;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic dma, output int v);
    @(negedge clk); #1;
    busAddr = a; busRd = 1'b1; busDma = dma;
    #1 v = int'(busRdata);
    @(negedge clk); #1;
    busRd = 1'b0; busDma = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output int v);
    busAddr = a;
    #1 v = int'(busRdata);
  endtask

  task automatic waitIdle();
    int v;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); #2;
      peek(3'd0, v);
      if (((v >> 5) & 1) == 0) break;
    end
  endtask

  task automatic waitLog(int n);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); #2;
      if (logN >= n) break;
    end
  endtask

  task automatic clearFlag(logic [7:0] keep);
    int v;
    rd(3'd0, 1'b0, v);
    wr(3'd0, keep);
  endtask

  task automatic testReset();
    int v;
    @(negedge clk); #2;
    peek(3'd0, v); chk("R1 csr", v, 0);
    for (int k = 0; k < 4; k++) begin
      peek(3'(4 + k), v); chk("R1 data", v, 0);
    end
    chk("R1 irq", int'(irq), 0);
    chk("R1 convStart", int'(convStart), 0);
  endtask

  task automatic testSingle();
    int v, base;
    base = logN;
    wr(3'd0, 8'h22);
    peek(3'd0, v); chk("R6 busy bit", (v >> 5) & 1, 1);
    waitIdle();
    peek(3'd0, v); chk("R6 csr after", v, 'h82);
    chk("R6 conv count", logN - base, 1);
    chk("R6 channel", chLog[base], 2);
    peek(3'd6, v); chk("R6 data ch2", v, lastRes[2]);
    chk("R5 irq off", int'(irq), 0);
  endtask

  task automatic testFlagClear();
    int v;
    wr(3'd0, 8'h02);
    peek(3'd0, v); chk("R3 no prior read", v, 'h82);
    rd(3'd0, 1'b0, v);
    wr(3'd0, 8'h82);
    peek(3'd0, v); chk("R3 write one keeps", v, 'h82);
    clearFlag(8'h02);
    peek(3'd0, v); chk("R3 cleared", v, 'h02);
    wr(3'd0, 8'h84);
    peek(3'd0, v); chk("R2 no set, bit2 zero", v, 'h00);
  endtask

  task automatic testIrqDma();
    int v;
    wr(3'd0, 8'h40);
    chk("R5 irq flag0", int'(irq), 0);
    wr(3'd0, 8'h61);
    waitIdle();
    peek(3'd0, v); chk("R6 csr ch1", v, 'hC1);
    chk("R5 irq on", int'(irq), 1);
    rd(3'd5, 1'b0, v); chk("R6 data ch1", v, lastRes[1]);
    peek(3'd0, v); chk("R4 cpu read keeps", (v >> 7) & 1, 1);
    rd(3'd5, 1'b1, v);
    peek(3'd0, v); chk("R4 dma read clears", (v >> 7) & 1, 0);
    chk("R5 irq after dma", int'(irq), 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic testMulti();
    int v, base;
    base = logN;
    wr(3'd0, 8'h2B);
    peek(3'd0, v); chk("R7 busy", (v >> 5) & 1, 1);
    wr(3'd0, 8'h33);
    waitIdle();
    peek(3'd0, v); chk("R2 cfg ignored busy", v, 'h8B);
    chk("R7 conv count", logN - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R7 order", chLog[base + k], k);
      peek(3'(4 + k), v); chk("R7 data", v, lastRes[k]);
    end
    clearFlag(8'h0B);
    peek(3'd0, v); chk("R3 clear multi", v, 'h0B);
  endtask

  task automatic testScan();
    int v, base, n;
    base = logN;
    wr(3'd0, 8'h31);
    waitLog(base + 5);
    peek(3'd0, v); chk("R8 running flagged", v, 'hB1);
    wr(3'd0, 8'h11);
    waitIdle();
    n = logN;
    repeat (20) @(negedge clk);
    chk("R9 scan stopped", logN, n);
    for (int i = base; i < n; i++) chk("R8 wrap order", chLog[i], (i - base) % 2);
    clearFlag(8'h0B);
  endtask

  task automatic testAbort();
    int v, base;
    base = logN;
    wr(3'd0, 8'h2B);
    waitLog(base + 1);
    wr(3'd0, 8'h0B);
    waitIdle();
    repeat (10) @(negedge clk);
    chk("R9 one channel", logN - base, 1);
    peek(3'd0, v); chk("R9 no flag", v, 'h0B);
    peek(3'd4, v); chk("R9 ch0 stored", v, lastRes[0]);
  endtask

  task automatic testTrigger();
    int v, base;
    wr(3'd0, 8'h00);
    base = logN;
    @(negedge clk); trigN = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 fall starts", logN - base, 1);
    peek(3'd0, v); chk("R10 flag after trig", v, 'h80);
    trigN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 rise ignored", logN - base, 1);
    clearFlag(8'h0B);
    base = logN;
    wr(3'd0, 8'h2B);
    repeat (2) @(negedge clk);
    trigN = 1'b0;
    waitIdle();
    repeat (10) @(negedge clk);
    chk("R10 fall while busy", logN - base, 4);
    trigN = 1'b1;
    repeat (5) @(negedge clk);
    clearFlag(8'h0B);
  endtask

  task automatic testStandby();
    int v, base, saved;
    peek(3'd4, saved);
    base = logN;
    wr(3'd0, 8'h2B);
    waitLog(base + 1);
    standbyReq = 1'b1;
    @(negedge clk); #1;
    standbyReq = 1'b0;
    #1 peek(3'd0, v); chk("R11 start cleared", v, 'h0B);
    repeat (20) @(negedge clk);
    chk("R11 no more conv", logN - base, 1);
    peek(3'd4, v); chk("R11 result dropped", v, saved);
    peek(3'd0, v); chk("R11 no flag", v, 'h0B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testFlagClear();
    testIrqDma();
    testMulti();
    testScan();
    testAbort();
    testTrigger();
    testStandby();
    summary();
    $finish;
  end
endmodule